// File: doc/BRIEF.md
# Exception pending control/status register

This block is the software-visible exception status and control register set of a nested interrupt controller. A processor reads one 32-bit status word. It shows the vector that is active now and the highest vector waiting to run. It also shows whether the active handler will return to the base level, whether any external interrupt is waiting, and the pending state of the three system exceptions: non-maskable interrupt, pendable service call and system tick. Vector numbers use hardware numbering, where external interrupts start at 16. A value of zero means "none".

Writes to the same word raise or drop those system exceptions. The block turns them into one-cycle set and clear strobes for the prioritiser. When one write word both sets and clears the same exception, the set wins. Priority arbitration is not part of this block.

Two more registers sit beside the status word. The first holds the vector table base, aligned to 128 bytes. The second is a keyed control register. A correctly keyed write to it can request a system reset.

Top module: `exc_pend_csr`

## Requirements
- R1: With `addr_i`=0, bits [VEC_W-1:0] of `rdata_o` equal `active_vec_i`. They read 0 when no exception is active.
- R2: With `addr_i`=0, bit 11 reads 1 when `active_vec_i` is 0 or `active_nested_i` is 0. Otherwise it reads 0.
- R3: With `addr_i`=0, bits [12+VEC_W-1:12] carry `pend_vec_i`, which is 0 when nothing is pending. Bit 22 equals `ext_pend_i`.
- R4: With `addr_i`=0, bits 26, 28 and 31 reflect `tick_pend_i`, `pendsv_pend_i` and `nmi_pend_i`. All other bits of the status word read 0.
- R5: A write to address 0 with bit 31 set pulses `nmi_set_o` for the one cycle that follows the write edge.
- R6: In a write to address 0, bit 28 pulses `pendsv_set_o`. Bit 27 pulses `pendsv_clr_o` only when bit 28 of the same word is 0.
- R7: In a write to address 0, bit 26 pulses `tick_set_o`. Bit 25 pulses `tick_clr_o` only when bit 26 of the same word is 0.
- R8: Zero bits in the status write word cause no strobe. Writes to addresses 1, 2 and 3 cause no set or clear strobe. Every strobe lasts one cycle.
- R9: A write to address 1 stores bits [31:7]. Address 1 and `vbase_o` return the stored bits with bits [6:0] as zero.
- R10: Address 2 reads 0xFA050000. A write to address 2 with bits [31:16] = 0x05FA and bit 2 set pulses `sys_reset_req_o` for one cycle. A wrong key, or bit 2 clear, gives no pulse.
- R11: After reset all strobes and `sys_reset_req_o` are 0 and the vector base is 0. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 2 | Register select: 0 status, 1 vector base, 2 keyed control, 3 unused |
| wr_i | input | 1 | Write enable, sampled on the rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| active_vec_i | input | VEC_W | Active vector number, 0 for none |
| pend_vec_i | input | VEC_W | Highest pending vector number, 0 for none |
| active_nested_i | input | 1 | Active exception has a preempted one beneath it |
| ext_pend_i | input | 1 | Any external interrupt pending |
| tick_pend_i | input | 1 | System tick pending |
| pendsv_pend_i | input | 1 | Pendable service call pending |
| nmi_pend_i | input | 1 | Non-maskable interrupt pending |
| nmi_set_o | output | 1 | Set-pending strobe, non-maskable interrupt |
| pendsv_set_o | output | 1 | Set-pending strobe, pendable service call |
| pendsv_clr_o | output | 1 | Clear-pending strobe, pendable service call |
| tick_set_o | output | 1 | Set-pending strobe, system tick |
| tick_clr_o | output | 1 | Clear-pending strobe, system tick |
| sys_reset_req_o | output | 1 | One-cycle system reset request |
| vbase_o | output | 32 | Vector table base |

## Verification
The status and control reads are combinational. They are due in the same cycle as the address and status inputs, so the bench changes those at a falling edge and compares a moment later. Strobes and the reset request are registered. They appear in the cycle after the rising edge that samples the write, and the vector base read changes from that same edge. The bench therefore drives each write at a falling edge and checks at the next falling edge. It checks once more one cycle later, to prove that each pulse has dropped.

// File: rtl/exc_csr_pkg.sv
package exc_csr_pkg;
  localparam int DW = 32;

  typedef enum logic [1:0] {
    CSR_STATUS = 2'd0,
    CSR_VBASE  = 2'd1,
    CSR_KEYCTL = 2'd2,
    CSR_NONE   = 2'd3
  } csr_sel_e;

  // status word layout
  localparam int BIT_RETBASE  = 11;
  localparam int PEND_LSB     = 12;
  localparam int BIT_EXTP     = 22;
  localparam int BIT_TICK_CLR = 25;
  localparam int BIT_TICK     = 26;
  localparam int BIT_PSV_CLR  = 27;
  localparam int BIT_PSV      = 28;
  localparam int BIT_NMI      = 31;

  // keyed control
  localparam int          KEY_LSB    = 16;
  localparam logic [15:0] KEY_WR     = 16'h05FA;
  localparam logic [15:0] KEY_RD     = 16'hFA05;
  localparam int          RSTREQ_BIT = 2;

  typedef struct packed {
    logic nmi_set;
    logic psv_set;
    logic psv_clr;
    logic tick_set;
    logic tick_clr;
  } pend_cmd_t;
endpackage

// File: rtl/exc_status_view.sv
module exc_status_view
  import exc_csr_pkg::*;
#(
  parameter int VEC_W = 9
) (
  input  logic [VEC_W-1:0] active_vec_i,
  input  logic [VEC_W-1:0] pend_vec_i,
  input  logic             active_nested_i,
  input  logic             ext_pend_i,
  input  logic             tick_pend_i,
  input  logic             pendsv_pend_i,
  input  logic             nmi_pend_i,
  output logic [DW-1:0]    word_o
);
  localparam int PEND_MSB = PEND_LSB + VEC_W - 1;

  logic no_active;
  assign no_active = (active_vec_i == '0);

  always_comb begin
    word_o                      = '0;
    word_o[VEC_W-1:0]           = active_vec_i;
    word_o[BIT_RETBASE]         = no_active | ~active_nested_i;
    word_o[PEND_MSB:PEND_LSB]   = pend_vec_i;
    word_o[BIT_EXTP]            = ext_pend_i;
    word_o[BIT_TICK]            = tick_pend_i;
    word_o[BIT_PSV]             = pendsv_pend_i;
    word_o[BIT_NMI]             = nmi_pend_i;
  end
endmodule

// File: rtl/exc_pend_strobes.sv
module exc_pend_strobes
  import exc_csr_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_i,
  input  pend_cmd_t cmd_i,
  output pend_cmd_t strb_o
);
  pend_cmd_t strb_d, strb_q;
  logic      armed_q;

  // a set request masks its paired clear
  always_comb begin
    strb_d.nmi_set  = wr_i & cmd_i.nmi_set;
    strb_d.psv_set  = wr_i & cmd_i.psv_set;
    strb_d.psv_clr  = wr_i & cmd_i.psv_clr & ~cmd_i.psv_set;
    strb_d.tick_set = wr_i & cmd_i.tick_set;
    strb_d.tick_clr = wr_i & cmd_i.tick_clr & ~cmd_i.tick_set;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strb_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      strb_q  <= strb_d;
      armed_q <= 1'b1;
    end
  end

  assign strb_o = strb_q;

  AST_PSV_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(wr_i && cmd_i.psv_set) |-> strb_q.psv_set && !strb_q.psv_clr); // R6
  AST_TICK_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(wr_i && cmd_i.tick_set) |-> strb_q.tick_set && !strb_q.tick_clr); // R7
  AST_NMI_FOLLOWS_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(wr_i && cmd_i.nmi_set) |-> strb_q.nmi_set); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && !$past(wr_i) |-> strb_q == '0); // R8
endmodule

// File: rtl/exc_sysctl_regs.sv
module exc_sysctl_regs
  import exc_csr_pkg::*;
#(
  parameter int ALIGN = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vbase_wr_i,
  input  logic [DW-1:ALIGN] vbase_i,
  input  logic             key_wr_i,
  input  logic [15:0]      key_i,
  input  logic             req_bit_i,
  output logic [DW-1:0]    vbase_o,
  output logic             rst_req_o
);
  logic [DW-1:ALIGN] vbase_q;
  logic              rst_req_q;
  logic              armed_q;
  logic              key_ok;

  assign key_ok = (key_i == KEY_WR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vbase_q   <= '0;
      rst_req_q <= 1'b0;
      armed_q   <= 1'b0;
    end else begin
      if (vbase_wr_i) vbase_q <= vbase_i;
      rst_req_q <= key_wr_i & key_ok & req_bit_i;
      armed_q   <= 1'b1;
    end
  end

  assign vbase_o   = {vbase_q, {ALIGN{1'b0}}};
  assign rst_req_o = rst_req_q;

  AST_VBASE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(vbase_wr_i) |-> vbase_o[DW-1:ALIGN] == $past(vbase_i)); // R9
  AST_BAD_KEY_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(key_wr_i && (key_i != KEY_WR)) |-> !rst_req_o); // R10
  AST_REQ_NEEDS_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && !$past(key_wr_i) |-> !rst_req_o); // R10
endmodule

// File: rtl/exc_pend_csr.sv
module exc_pend_csr
  import exc_csr_pkg::*;
#(
  parameter int VEC_W = 9,
  parameter int ALIGN = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       addr_i,
  input  logic             wr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic [VEC_W-1:0] active_vec_i,
  input  logic [VEC_W-1:0] pend_vec_i,
  input  logic             active_nested_i,
  input  logic             ext_pend_i,
  input  logic             tick_pend_i,
  input  logic             pendsv_pend_i,
  input  logic             nmi_pend_i,
  output logic             nmi_set_o,
  output logic             pendsv_set_o,
  output logic             pendsv_clr_o,
  output logic             tick_set_o,
  output logic             tick_clr_o,
  output logic             sys_reset_req_o,
  output logic [31:0]      vbase_o
);
  csr_sel_e  sel;
  logic      wr_status, wr_vbase, wr_key;
  pend_cmd_t cmd, strb;
  logic [DW-1:0] status_word;
  logic unused_wdata;

  assign sel       = csr_sel_e'(addr_i);
  assign wr_status = wr_i & (sel == CSR_STATUS);
  assign wr_vbase  = wr_i & (sel == CSR_VBASE);
  assign wr_key    = wr_i & (sel == CSR_KEYCTL);

  assign cmd.nmi_set  = wdata_i[BIT_NMI];
  assign cmd.psv_set  = wdata_i[BIT_PSV];
  assign cmd.psv_clr  = wdata_i[BIT_PSV_CLR];
  assign cmd.tick_set = wdata_i[BIT_TICK];
  assign cmd.tick_clr = wdata_i[BIT_TICK_CLR];
  assign unused_wdata = ^{wdata_i[6:3], wdata_i[1:0]};

  exc_status_view #(.VEC_W(VEC_W)) u_view (
    .active_vec_i    (active_vec_i),
    .pend_vec_i      (pend_vec_i),
    .active_nested_i (active_nested_i),
    .ext_pend_i      (ext_pend_i),
    .tick_pend_i     (tick_pend_i),
    .pendsv_pend_i   (pendsv_pend_i),
    .nmi_pend_i      (nmi_pend_i),
    .word_o          (status_word)
  );

  exc_pend_strobes u_strobes (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_status),
    .cmd_i  (cmd),
    .strb_o (strb)
  );

  exc_sysctl_regs #(.ALIGN(ALIGN)) u_sysctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vbase_wr_i (wr_vbase),
    .vbase_i    (wdata_i[DW-1:ALIGN]),
    .key_wr_i   (wr_key),
    .key_i      (wdata_i[KEY_LSB +: 16]),
    .req_bit_i  (wdata_i[RSTREQ_BIT]),
    .vbase_o    (vbase_o),
    .rst_req_o  (sys_reset_req_o)
  );

  always_comb begin
    unique case (sel)
      CSR_STATUS: rdata_o = status_word;
      CSR_VBASE:  rdata_o = vbase_o;
      CSR_KEYCTL: rdata_o = {KEY_RD, 16'h0000};
      default:    rdata_o = '0;
    endcase
  end

  assign nmi_set_o    = strb.nmi_set;
  assign pendsv_set_o = strb.psv_set;
  assign pendsv_clr_o = strb.psv_clr;
  assign tick_set_o   = strb.tick_set;
  assign tick_clr_o   = strb.tick_clr;

  AST_RD_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == CSR_STATUS) |-> rdata_o[VEC_W-1:0] == active_vec_i); // R1
  AST_IDLE_RETBASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == CSR_STATUS) && (active_vec_i == '0) |-> rdata_o[BIT_RETBASE]); // R2
  AST_RD_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == CSR_STATUS) |-> rdata_o[BIT_EXTP] == ext_pend_i); // R3
  AST_KEY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == CSR_KEYCTL) |-> rdata_o == 32'hFA05_0000); // R10
  AST_NO_STROBE_OTHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && (sel != CSR_STATUS) |=> !(nmi_set_o || pendsv_set_o || pendsv_clr_o
                                      || tick_set_o || tick_clr_o)); // R8
endmodule

// File: tb/exc_pend_csr_test.sv
module exc_pend_csr_test;
  localparam int VEC_W = 9;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [1:0]       addr_i = '0;
  logic             wr_i = 1'b0;
  logic [31:0]      wdata_i = '0;
  logic [31:0]      rdata_o;
  logic [VEC_W-1:0] active_vec_i = '0;
  logic [VEC_W-1:0] pend_vec_i = '0;
  logic             active_nested_i = 1'b0;
  logic             ext_pend_i = 1'b0;
  logic             tick_pend_i = 1'b0;
  logic             pendsv_pend_i = 1'b0;
  logic             nmi_pend_i = 1'b0;
  logic             nmi_set_o, pendsv_set_o, pendsv_clr_o, tick_set_o, tick_clr_o;
  logic             sys_reset_req_o;
  logic [31:0]      vbase_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  exc_pend_csr #(.VEC_W(VEC_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .active_vec_i(active_vec_i), .pend_vec_i(pend_vec_i),
    .active_nested_i(active_nested_i), .ext_pend_i(ext_pend_i),
    .tick_pend_i(tick_pend_i), .pendsv_pend_i(pendsv_pend_i), .nmi_pend_i(nmi_pend_i),
    .nmi_set_o(nmi_set_o), .pendsv_set_o(pendsv_set_o), .pendsv_clr_o(pendsv_clr_o),
    .tick_set_o(tick_set_o), .tick_clr_o(tick_clr_o),
    .sys_reset_req_o(sys_reset_req_o), .vbase_o(vbase_o)
  );

  // {tag, addr, wdata, expected {nmi_set, psv_set, psv_clr, tick_set, tick_clr, rst_req}}
  localparam int NV = 15;
  localparam logic [43:0] VECS [NV] = '{
    {4'd5,  2'd0, 32'h8000_0000, 6'b100000},  // R5 nmi set
    {4'd6,  2'd0, 32'h1000_0000, 6'b010000},  // R6 pendsv set
    {4'd6,  2'd0, 32'h0800_0000, 6'b001000},  // R6 pendsv clear
    {4'd6,  2'd0, 32'h1800_0000, 6'b010000},  // R6 set beats clear
    {4'd7,  2'd0, 32'h0400_0000, 6'b000100},  // R7 tick set
    {4'd7,  2'd0, 32'h0200_0000, 6'b000010},  // R7 tick clear
    {4'd7,  2'd0, 32'h0600_0000, 6'b000100},  // R7 set beats clear
    {4'd8,  2'd0, 32'h0000_0000, 6'b000000},  // R8 all zero
    {4'd8,  2'd0, 32'h6DFF_FFFF, 6'b001100},  // R8 mixed word
    {4'd8,  2'd0, 32'hFE00_0000, 6'b110100},  // R8 all command bits
    {4'd8,  2'd3, 32'hFFFF_FFFF, 6'b000000},  // R8 unused address
    {4'd8,  2'd1, 32'h9400_0000, 6'b000000},  // R8 base register write
    {4'd10, 2'd2, 32'h05FA_0004, 6'b000001},  // R10 keyed reset
    {4'd10, 2'd2, 32'h05FB_0004, 6'b000000},  // R10 wrong key
    {4'd10, 2'd2, 32'h05FA_0000, 6'b000000}   // R10 request bit clear
  };

  function automatic logic [5:0] outs();
    return {nmi_set_o, pendsv_set_o, pendsv_clr_o, tick_set_o, tick_clr_o, sys_reset_req_o};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_word(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr_i = a; wr_i = 1'b1; wdata_i = d;
    @(negedge clk);
    wr_i = 1'b0; wdata_i = '0;
  endtask

  task automatic read_word(input logic [1:0] a, input string req, input logic [31:0] exp);
    @(negedge clk);
    addr_i = a;
    #1 check(req, rdata_o, exp);
  endtask

  task automatic set_status(input logic [VEC_W-1:0] act, input logic nest,
                            input logic [VEC_W-1:0] pnd, input logic ext,
                            input logic tk, input logic psv, input logic nmi);
    active_vec_i = act; active_nested_i = nest; pend_vec_i = pnd;
    ext_pend_i = ext; tick_pend_i = tk; pendsv_pend_i = psv; nmi_pend_i = nmi;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R11 reset state
    @(negedge clk);
    check("R11 outputs", {26'd0, outs()}, 32'd0);
    check("R11 vbase", vbase_o, 32'd0);
    read_word(2'd1, "R11 base read", 32'd0);
    read_word(2'd3, "R11 unused read", 32'd0);
    read_word(2'd2, "R10 key read", 32'hFA05_0000);

    // R1 R2 R3 R4 status word patterns
    set_status(9'h025, 1'b1, 9'h013, 1'b1, 1'b1, 1'b0, 1'b1);
    read_word(2'd0, "R1/R3/R4 pattern A", 32'h8441_3025);
    set_status(9'h000, 1'b1, 9'h000, 1'b0, 1'b0, 1'b1, 1'b0);
    read_word(2'd0, "R2 idle pattern B", 32'h1000_0800);
    set_status(9'h003, 1'b0, 9'h1FF, 1'b1, 1'b0, 1'b0, 1'b0);
    read_word(2'd0, "R2/R3 pattern C", 32'h005F_F803);
    set_status('0, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
    read_word(2'd0, "R4 quiet word", 32'h0000_0800);

    // table walk: pulse due one cycle after write edge, gone the next
    for (int i = 0; i < NV; i++) begin
      write_word(VECS[i][39:38], VECS[i][37:6]);
      checks++;
      if (outs() !== VECS[i][5:0]) begin
        failures++;
        $display("FAIL R%0d vec %0d actual=%b expected=%b", VECS[i][43:40], i, outs(), VECS[i][5:0]);
      end
      @(negedge clk);
      check("R8 pulse width", {26'd0, outs()}, 32'd0);
    end

    // R9 base alignment
    read_word(2'd1, "R9 base after table", 32'h9400_0000);
    write_word(2'd1, 32'hFFFF_FFFF);
    check("R9 vbase_o", vbase_o, 32'hFFFF_FF80);
    read_word(2'd1, "R9 base read", 32'hFFFF_FF80);
    write_word(2'd1, 32'h1234_567F);
    read_word(2'd1, "R9 base low bits", 32'h1234_5600);
    read_word(2'd2, "R10 key read unchanged", 32'hFA05_0000);

    // R11 reset mid-run clears base
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R11 base after reset", vbase_o, 32'd0);
    check("R11 outputs after reset", {26'd0, outs()}, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule